// File: doc/BRIEF.md
# Interrupt Capture and Replay Controller

This block sits in front of a downstream interrupt controller and watches a bank of external interrupt lines. Each line passes through a two-stage synchronizer. The selected event (rising or falling edge, or high or low level) is then latched into a per-line status bit. Recording continues while the block is disabled and while a line is masked, so events that arrive while the system is asleep are not lost.

On wake-up, software enables the block and issues a flush command. In the cycle after the flush is accepted, every recorded line that is not masked produces one single-cycle pulse on its replay output, and its status bit is cleared. An edge-only mode restricts recording to edge events during sleep. Software reaches all per-line settings through a small register port. Each per-line field has a write-one-to-set word and a write-one-to-clear word, and the status bits have a write-one-to-acknowledge word.

Top module: `irq_replay_ctrl`

## Requirements
- R1: After a synchronous reset the following values hold. Every line is masked, edge-sensitive and set to the high/rising polarity. All status bits are 0. The control word reads 0. `replay_o` is 0 and `rdata_o` is 0.
- R2: Line n maps to bit n%32 of word n/32. The word sits at byte address group_base + 4*(n/32). The group bases are 0x040 (acknowledge), 0x0C0/0x100 (mask set/clear), 0x180/0x1C0 (sensitivity set/clear) and 0x240/0x280 (polarity set/clear). Writing a 1 to a set or clear word sets or clears only that line's bit. A 0 leaves the bit unchanged. Addresses with a[1:0] other than 0 are ignored.
- R3: A read strobe returns, on `rdata_o` one clock edge later, the values held before that edge. The mask, sensitivity and polarity values read back at either their set or their clear address. The acknowledge address returns the status bits. Control (0x300) returns enable in bit 0, edge-only in bit 1 and flush in bit 2. `rdata_o` holds its value between reads.
- R4: A change on `irq_i` is first able to set a status bit on the third rising clock edge after the input changes.
- R5: A line with sensitivity 0 records on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The opposite edge is ignored.
- R6: A line with sensitivity 1 records on every cycle its synchronized input is at the active level (high when polarity is 1, low when polarity is 0).
- R7: Status is recorded regardless of the enable bit and regardless of the line's mask bit.
- R8: Writing 1 to a line's acknowledge bit clears its status. If the line's event occurs in the same cycle, the event wins.
- R9: While edge-only mode (control bit 1) is set, level-sensitive lines record only the edge toward their active level.
- R10: A control write with flush=1 and enable=1 replays the lines. On the next clock edge, each recorded, unmasked line drives a one-cycle pulse on `replay_o` and its status bit clears. The flush bit is set for exactly one cycle.
- R11: A masked line is never pulsed and keeps its status across a flush.
- R12: A flush written with enable=0 self-clears after one cycle. It produces no pulse and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_LINES | Asynchronous external interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| replay_o | output | NUM_LINES | One-cycle replay pulse per line |

## Verification
An input change reaches the status bits on the third clock edge after it. A read returns, one edge after its strobe, the state as it stood before that edge. Replay pulses appear on the edge after the flush write and last exactly one cycle. The bench drives every stimulus just after a falling edge. It runs a behavioural model on each rising edge and compares `replay_o` and `rdata_o` at the following falling edge. The directed reads are placed so that a read lands either just before or just after the edge on which a status bit is due, which pins down each latency exactly.

// File: rtl/irq_replay_pkg.sv
package irq_replay_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WSEL_W = 4;

    // Register groups; each group owns a 64-byte address window.
    typedef enum logic [3:0] {
        RG_NONE    = 4'd0,
        RG_ACK     = 4'd1,
        RG_MSK_SET = 4'd2,
        RG_MSK_CLR = 4'd3,
        RG_SEN_SET = 4'd4,
        RG_SEN_CLR = 4'd5,
        RG_POL_SET = 4'd6,
        RG_POL_CLR = 4'd7,
        RG_CTRL    = 4'd8
    } reg_grp_e;

    typedef struct packed {
        logic flush;
        logic edge_only;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        reg_grp_e           grp;
        logic [WSEL_W-1:0]  word;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.word = a[5:2];
        case (a[11:6])
            6'd1:    d.grp = RG_ACK;
            6'd3:    d.grp = RG_MSK_SET;
            6'd4:    d.grp = RG_MSK_CLR;
            6'd6:    d.grp = RG_SEN_SET;
            6'd7:    d.grp = RG_SEN_CLR;
            6'd9:    d.grp = RG_POL_SET;
            6'd10:   d.grp = RG_POL_CLR;
            6'd12:   d.grp = (a[5:2] == '0) ? RG_CTRL : RG_NONE;
            default: d.grp = RG_NONE;
        endcase
        if (a[1:0] != 2'b00) d.grp = RG_NONE;
        return d;
    endfunction

    // Event for one line given current/previous synchronized samples.
    function automatic logic line_hit(input logic cur, input logic prev,
                                      input logic level_sel, input logic act_high,
                                      input logic edge_only);
        logic lvl, edg;
        lvl = act_high ? cur : ~cur;
        edg = act_high ? (cur & ~prev) : (~cur & prev);
        return (level_sel && !edge_only) ? lvl : edg;
    endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LINES-1:0] async_i,
    output logic [NUM_LINES-1:0] cur_o,
    output logic [NUM_LINES-1:0] prev_o
);
    logic [NUM_LINES-1:0] meta_q, cur_q, prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

    // R4: the compared sample is the one-cycle-old synchronized value
    prev_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> prev_q == $past(cur_q));
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect
    import irq_replay_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic [NUM_LINES-1:0] cur_i,
    input  logic [NUM_LINES-1:0] prev_i,
    input  logic [NUM_LINES-1:0] sens_i,
    input  logic [NUM_LINES-1:0] pol_i,
    input  logic                 edge_only_i,
    output logic [NUM_LINES-1:0] event_o
);
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign event_o[n] = line_hit(cur_i[n], prev_i[n], sens_i[n],
                                     pol_i[n], edge_only_i);
    end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_replay_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic [NUM_LINES-1:0] status_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] sens_o,
    output logic [NUM_LINES-1:0] pol_o,
    output ctrl_t                ctrl_o,
    output logic [NUM_LINES-1:0] ack_o
);
    // NUM_LINES is expected to be a multiple of 32, at most 512.
    localparam int unsigned NW = NUM_LINES / WORD_W;

    reg_dec_t             dec;
    logic [NUM_LINES-1:0] mask_q, sens_q, pol_q;
    ctrl_t                ctrl_q;
    logic [WORD_W-1:0]    rd_val, rdata_q;

    assign dec = decode_addr(addr_i);

    function automatic logic [WORD_W-1:0] pick_word(input logic [NUM_LINES-1:0] v,
                                                    input logic [WSEL_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < NW; k++)
            if (w == k[WSEL_W-1:0]) r = v[k*WORD_W +: WORD_W];
        return r;
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '1;
            sens_q <= '0;
            pol_q  <= '1;
        end else if (wr_en_i) begin
            for (int k = 0; k < NW; k++) begin
                if (dec.word == k[WSEL_W-1:0]) begin
                    case (dec.grp)
                        RG_MSK_SET: mask_q[k*WORD_W +: WORD_W] <= mask_q[k*WORD_W +: WORD_W] | wdata_i;
                        RG_MSK_CLR: mask_q[k*WORD_W +: WORD_W] <= mask_q[k*WORD_W +: WORD_W] & ~wdata_i;
                        RG_SEN_SET: sens_q[k*WORD_W +: WORD_W] <= sens_q[k*WORD_W +: WORD_W] | wdata_i;
                        RG_SEN_CLR: sens_q[k*WORD_W +: WORD_W] <= sens_q[k*WORD_W +: WORD_W] & ~wdata_i;
                        RG_POL_SET: pol_q[k*WORD_W +: WORD_W]  <= pol_q[k*WORD_W +: WORD_W] | wdata_i;
                        RG_POL_CLR: pol_q[k*WORD_W +: WORD_W]  <= pol_q[k*WORD_W +: WORD_W] & ~wdata_i;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Flush is a one-cycle command bit; a write in that cycle keeps it clear.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_q.flush) ctrl_q.flush <= 1'b0;
            if (wr_en_i && dec.grp == RG_CTRL) begin
                ctrl_q.enable    <= wdata_i[0];
                ctrl_q.edge_only <= wdata_i[1];
                if (!ctrl_q.flush) ctrl_q.flush <= wdata_i[2];
            end
        end
    end

    for (genvar k = 0; k < NW; k++) begin : g_ack
        assign ack_o[k*WORD_W +: WORD_W] =
            (wr_en_i && dec.grp == RG_ACK && dec.word == WSEL_W'(k)) ? wdata_i : '0;
    end

    always_comb begin
        case (dec.grp)
            RG_ACK:                 rd_val = pick_word(status_i, dec.word);
            RG_MSK_SET, RG_MSK_CLR: rd_val = pick_word(mask_q, dec.word);
            RG_SEN_SET, RG_SEN_CLR: rd_val = pick_word(sens_q, dec.word);
            RG_POL_SET, RG_POL_CLR: rd_val = pick_word(pol_q, dec.word);
            RG_CTRL:                rd_val = {{(WORD_W-3){1'b0}}, ctrl_q};
            default:                rd_val = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_val;
    end

    assign rdata_o = rdata_q;
    assign mask_o  = mask_q;
    assign sens_o  = sens_q;
    assign pol_o   = pol_q;
    assign ctrl_o  = ctrl_q;

    // R10
    flush_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_q.flush |=> !ctrl_q.flush);
    // R2
    mask_set_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && dec.grp == RG_MSK_SET) |=> (mask_q & $past(mask_q)) == $past(mask_q));
    // R3
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/irq_status_replay.sv
module irq_status_replay #(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LINES-1:0] event_i,
    input  logic [NUM_LINES-1:0] ack_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 enable_i,
    input  logic                 flush_i,
    output logic [NUM_LINES-1:0] status_o,
    output logic [NUM_LINES-1:0] replay_o
);
    logic [NUM_LINES-1:0] status_q, replay_q, sent;

    assign sent = (flush_i && enable_i) ? (status_q & ~mask_i) : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_q <= '0;
            replay_q <= '0;
        end else begin
            status_q <= (status_q & ~ack_i & ~sent) | event_i;
            replay_q <= sent;
        end
    end

    assign status_o = status_q;
    assign replay_o = replay_q;

    // R7
    status_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_q & ~$past(status_q) & ~$past(event_i)) == '0);
    // R8
    ack_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_q & $past(ack_i) & ~$past(event_i)) == '0);
    // R11
    replay_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (replay_q & $past(mask_i)) == '0);
    // R10
    replay_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|replay_q) |=> replay_q == '0);
    // R12
    replay_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|replay_q) |-> $past(enable_i && flush_i));
endmodule

// File: rtl/irq_replay_ctrl.sv
module irq_replay_ctrl
    import irq_replay_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic [NUM_LINES-1:0] replay_o
);
    logic [NUM_LINES-1:0] cur, prev, evt, mask, sens, pol, ack, status;
    ctrl_t                ctrl;

    irq_line_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .async_i(irq_i),
        .cur_o(cur), .prev_o(prev)
    );

    irq_event_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .cur_i(cur), .prev_i(prev), .sens_i(sens), .pol_i(pol),
        .edge_only_i(ctrl.edge_only), .event_o(evt)
    );

    irq_reg_file #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status),
        .rdata_o(rdata_o), .mask_o(mask), .sens_o(sens), .pol_o(pol),
        .ctrl_o(ctrl), .ack_o(ack)
    );

    irq_status_replay #(.NUM_LINES(NUM_LINES)) u_status (
        .clk_i(clk_i), .rst_i(rst_i), .event_i(evt), .ack_i(ack),
        .mask_i(mask), .enable_i(ctrl.enable), .flush_i(ctrl.flush),
        .status_o(status), .replay_o(replay_o)
    );
endmodule

// File: tb/irq_replay_ctrl_tb_top.sv
module irq_replay_ctrl_tb_top;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  replay;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_replay_ctrl #(.NUM_LINES(N)) dut_i (
        .clk_i(clk), .rst_i(rst), .irq_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .replay_o(replay)
    );

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_s1, m_cur, m_prev, m_status, m_mask, m_sens, m_pol, m_replay;
    logic [N-1:0] ev, ackv, rp;
    logic         m_en, m_eo, m_fl;
    logic [31:0]  m_rdata, rv;
    int           grp, wi;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_cur = '0; m_prev = '0; m_status = '0;
            m_mask = '1; m_sens = '0; m_pol = '1; m_replay = '0;
            m_en = 0; m_eo = 0; m_fl = 0; m_rdata = '0;
        end else begin
            grp = int'(addr[11:6]);
            wi  = int'(addr[5:2]);
            for (int i = 0; i < N; i++) begin
                if (m_sens[i] && !m_eo)
                    ev[i] = m_pol[i] ? m_cur[i] : !m_cur[i];
                else
                    ev[i] = m_pol[i] ? (m_cur[i] && !m_prev[i]) : (!m_cur[i] && m_prev[i]);
            end
            ackv = '0;
            rv = '0;
            if (addr[1:0] == 2'b00 && wi < 2) begin
                case (grp)
                    1: rv = m_status[wi*32 +: 32];
                    3, 4: rv = m_mask[wi*32 +: 32];
                    6, 7: rv = m_sens[wi*32 +: 32];
                    9, 10: rv = m_pol[wi*32 +: 32];
                    12: if (wi == 0) rv = {29'd0, m_fl, m_eo, m_en};
                    default: rv = '0;
                endcase
            end
            if (rd_en) m_rdata = rv;
            rp = (m_fl && m_en) ? (m_status & ~m_mask) : '0;
            if (wr_en && addr[1:0] == 2'b00 && wi < 2) begin
                case (grp)
                    1: ackv[wi*32 +: 32] = wdata;
                    default: ;
                endcase
            end
            m_status = (m_status & ~ackv & ~rp) | ev;
            m_replay = rp;
            if (wr_en && addr[1:0] == 2'b00 && wi < 2) begin
                case (grp)
                    3:  m_mask[wi*32 +: 32] = m_mask[wi*32 +: 32] | wdata;
                    4:  m_mask[wi*32 +: 32] = m_mask[wi*32 +: 32] & ~wdata;
                    6:  m_sens[wi*32 +: 32] = m_sens[wi*32 +: 32] | wdata;
                    7:  m_sens[wi*32 +: 32] = m_sens[wi*32 +: 32] & ~wdata;
                    9:  m_pol[wi*32 +: 32]  = m_pol[wi*32 +: 32] | wdata;
                    10: m_pol[wi*32 +: 32]  = m_pol[wi*32 +: 32] & ~wdata;
                    default: ;
                endcase
            end
            if (wr_en && addr == 12'h300) begin
                m_en = wdata[0];
                m_eo = wdata[1];
                m_fl = m_fl ? 1'b0 : wdata[2];
            end else begin
                m_fl = 1'b0;
            end
            m_prev = m_cur;
            m_cur  = m_s1;
            m_s1   = irq;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R3 / R10: every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(replay === m_replay, "R10 replay vs model", replay, m_replay);
            chk(rdata === m_rdata, "R3 rdata vs model", {32'd0, rdata}, {32'd0, m_rdata});
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        chk(rdata === exp, tag, {32'd0, rdata}, {32'd0, exp});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(replay === '0, "R1 replay after reset", replay, '0);
        chk(rdata === '0, "R1 rdata after reset", {32'd0, rdata}, '0);
        rd_chk(12'h0C0, 32'hFFFF_FFFF, "R1 mask word0");
        rd_chk(12'h0C4, 32'hFFFF_FFFF, "R1 mask word1");
        rd_chk(12'h180, 32'h0, "R1 sensitivity word0");
        rd_chk(12'h240, 32'hFFFF_FFFF, "R1 polarity word0");
        rd_chk(12'h040, 32'h0, "R1 status word0");
        rd_chk(12'h300, 32'h0, "R1 control");
        // R2 set/clear semantics, R3 readback at clear address
        reg_wr(12'h104, 32'h0000_0105);
        reg_wr(12'h0C4, 32'h0000_0100);
        reg_wr(12'h101, 32'h0000_00FF);   // misaligned: ignored
        rd_chk(12'h0C4, 32'hFFFF_FFFA, "R2 mask word1 after clear/set");
        reg_wr(12'h100, 32'h0000_0038);
        rd_chk(12'h100, 32'hFFFF_FFC7, "R3 mask word0 read at clear address");
        // R4 latency: rising edge on line 3
        irq[3] = 1'b1;
        tick(2);
        rd_chk(12'h040, 32'h0, "R4 status not yet set");
        rd_chk(12'h040, 32'h0000_0008, "R4 status set on third edge");
        // R8 acknowledge
        reg_wr(12'h040, 32'h0000_0008);
        rd_chk(12'h040, 32'h0, "R8 status cleared by ack");
        // R5 falling polarity on line 4
        reg_wr(12'h280, 32'h0000_0010);
        irq[4] = 1'b1;
        tick(4);
        rd_chk(12'h040, 32'h0, "R5 rising edge ignored on falling line");
        irq[4] = 1'b0;
        tick(4);
        rd_chk(12'h040, 32'h0000_0010, "R5 falling edge recorded");
        reg_wr(12'h040, 32'h0000_0010);
        // R6 level high on line 5
        reg_wr(12'h180, 32'h0000_0020);
        irq[5] = 1'b1;
        tick(4);
        rd_chk(12'h040, 32'h0000_0020, "R6 level recorded");
        reg_wr(12'h040, 32'h0000_0020);
        rd_chk(12'h040, 32'h0000_0020, "R6 level re-records after ack");
        // R9 edge-only mode
        reg_wr(12'h300, 32'h0000_0002);
        reg_wr(12'h040, 32'h0000_0020);
        tick(3);
        rd_chk(12'h040, 32'h0, "R9 held level not recorded in edge-only");
        rd_chk(12'h300, 32'h0000_0002, "R3 control readback edge-only");
        irq[5] = 1'b0;
        tick(3);
        irq[5] = 1'b1;
        tick(4);
        rd_chk(12'h040, 32'h0000_0020, "R9 edge recorded in edge-only");
        irq[5] = 1'b0;
        tick(3);
        reg_wr(12'h300, 32'h0000_0000);
        // R7 recording while disabled and while masked
        irq[3] = 1'b0;
        tick(3);
        irq[3] = 1'b1;
        irq[34] = 1'b1;
        irq[40] = 1'b1;
        tick(4);
        rd_chk(12'h044, 32'h0000_0104, "R7 masked and unmasked lines recorded");
        rd_chk(12'h040, 32'h0000_0028, "R7 recorded with enable clear");
        // R12 flush without enable
        reg_wr(12'h300, 32'h0000_0004);
        tick(1);
        chk(replay === '0, "R12 no replay when disabled", replay, '0);
        rd_chk(12'h300, 32'h0, "R12 flush self-cleared");
        rd_chk(12'h040, 32'h0000_0028, "R12 status kept");
        // R10 / R11 flush with enable
        reg_wr(12'h300, 32'h0000_0005);
        @(posedge clk); @(negedge clk);
        chk(replay === 64'h0000_0004_0000_0028, "R10 replay pulse",
            replay, 64'h0000_0004_0000_0028);
        tick(1);
        chk(replay === '0, "R10 pulse lasts one cycle", replay, '0);
        rd_chk(12'h040, 32'h0, "R10 replayed status cleared");
        rd_chk(12'h044, 32'h0000_0100, "R11 masked line kept and not replayed");
        rd_chk(12'h300, 32'h0000_0001, "R10 flush cleared, enable kept");
        tick(2);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end
endmodule